// File: doc/BRIEF.md
# Matrix Keypad Scanner with Debounce

This block serves a 4x4 key matrix wired as four column drive lines and four active-low row sense lines. While waiting, it pulls every column low, so any pressed key drags its row low. When the synchronised row pattern changes, the block records the new pattern and marks itself busy. It then waits out a debounce interval and walks the columns one at a time. From the matching column it forms an 8-bit key code, which it reports with a single-cycle strobe.

After a report, or after a release with nothing to report, a second debounce interval runs. The columns are then pulled low again. After a short settle period the block goes back to watching the rows. A change that happens while the block is busy is still detected on return, because the reference pattern stays frozen outside the waiting state. The code is the raw concatenation of the active-high row pattern and the column drive nibble. Mapping codes to actions is left to the consumer.

Top module: `kp_scanner`

## Requirements
- R1: After reset, and whenever the block is not busy, all column outputs are 0, busy is low and the valid strobe is low.
- R2: Row inputs pass through two flip-flops. While not busy, a difference between the inverted (active-high) rows and the last recorded pattern raises busy within a few cycles and records that pattern.
- R3: No column is driven to a non-zero value until at least DEB_CYC cycles after busy rises. Row bounce during that interval starts no further event.
- R4: The scan drives a single 0 per nibble in the order 0111, 1011, 1101, 1110, where nibble bit c drives column c. Each value is held for at least SETTLE_CYC cycles.
- R5: Key code bits 7:4 hold the active-high row pattern, with bit 4+r set for row r. Bits 3:0 hold the column nibble that was driven. The key at row 0, column 3 gives 0x17, and the key at row 3, column 0 gives 0x8E.
- R6: A column matches only when the inverted rows equal the recorded pattern and are non-zero. If no column matches, no strobe is produced.
- R7: When several columns match, the one scanned last wins.
- R8: If the recorded pattern is zero (a release), no column is scanned and no strobe is produced, but busy still goes through the closing delay.
- R9: The valid strobe lasts exactly one cycle and occurs only while busy. The key code output holds its value until the next report.
- R10: After a report, at least DEB_CYC cycles pass before the columns return to 0 and busy falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| row_n_i | input | 4 | Row sense lines, active low, asynchronous |
| col_o | output | 4 | Column drive nibble, 0 selects a column |
| key_code_o | output | 8 | Row pattern (7:4) and column nibble (3:0) of the last report |
| key_valid_o | output | 1 | One-cycle strobe marking a new key code |
| busy_o | output | 1 | High from detection until the block is idle again |

## Verification
On every cycle, the assertions check:
- the column-drive rules: all zero when idle, a single 0 while scanning, the fixed rotation order, and the minimum hold per column;
- the shape of the strobe and the format of the code;
- that a release never produces a strobe.

The bench scenarios cover what depends on the key matrix itself. These are which code each key produces, last-match-wins across columns, the no-match and release cases, and the length of the two debounce intervals as seen at the ports.

// File: rtl/kp_pkg.sv
package kp_pkg;

    localparam int KP_ROWS = 4;
    localparam int KP_COLS = 4;
    localparam int KP_CODE_W = KP_ROWS + KP_COLS;

    localparam logic [KP_COLS-1:0] COL_FIRST = ~(KP_COLS'(1) << (KP_COLS - 1));

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEBOUNCE,
        ST_SCAN,
        ST_REPORT,
        ST_CLOSE,
        ST_REARM
    } kp_state_e;

    typedef struct packed {
        logic [KP_ROWS-1:0] row;
        logic [KP_COLS-1:0] col;
    } kp_code_t;

    function automatic logic [KP_COLS-1:0] next_col(input logic [KP_COLS-1:0] c);
        return {c[0], c[KP_COLS-1:1]};
    endfunction

    function automatic logic last_col(input logic [KP_COLS-1:0] c);
        return ~c[0];
    endfunction

endpackage

// File: rtl/kp_row_sync.sv
module kp_row_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '1;
            sync_q <= '1;
        end else begin
            meta_q <= d_i;
            sync_q <= meta_q;
        end
    end

    assign q_o = sync_q;
endmodule

// File: rtl/kp_delay_timer.sv
module kp_delay_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [CNT_W-1:0] len_i,
    output logic             done_o
);
    logic [CNT_W-1:0] cnt_q;
    logic             run_q;
    logic             done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            run_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start_i) begin
                cnt_q <= len_i;
                run_q <= 1'b1;
            end else if (run_q) begin
                if (cnt_q <= CNT_W'(1)) begin
                    run_q  <= 1'b0;
                    done_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q - CNT_W'(1);
                end
            end
        end
    end

    assign done_o = done_q;

    // a single expiry per load: done never lasts two cycles (R3, R10)
    p_done_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);
endmodule

// File: rtl/kp_scan_ctrl.sv
module kp_scan_ctrl
    import kp_pkg::*;
#(
    parameter int DEB_CYC    = 20,
    parameter int SETTLE_CYC = 4,
    parameter int CNT_W      = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [KP_ROWS-1:0] rows_act_i,
    input  logic               tmr_done_i,
    output logic               tmr_start_o,
    output logic [CNT_W-1:0]   tmr_len_o,
    output logic [KP_COLS-1:0] col_o,
    output kp_code_t           code_o,
    output logic               valid_o,
    output logic               busy_o
);
    localparam logic [CNT_W-1:0] DEB_LEN = CNT_W'(DEB_CYC);
    localparam logic [CNT_W-1:0] SET_LEN = CNT_W'(SETTLE_CYC);

    kp_state_e          state_q;
    logic [KP_ROWS-1:0] ref_q;
    logic [KP_ROWS-1:0] latched_q;
    logic [KP_COLS-1:0] drive_q;
    logic               found_q;
    kp_code_t           cand_q;
    kp_code_t           code_q;
    logic               valid_q;
    logic               tstart_q;
    logic [CNT_W-1:0]   tlen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            ref_q     <= '0;
            latched_q <= '0;
            drive_q   <= '0;
            found_q   <= 1'b0;
            cand_q    <= '0;
            code_q    <= '0;
            valid_q   <= 1'b0;
            tstart_q  <= 1'b0;
            tlen_q    <= '0;
        end else begin
            tstart_q <= 1'b0;
            valid_q  <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    drive_q <= '0;
                    if (rows_act_i != ref_q) begin
                        ref_q     <= rows_act_i;
                        latched_q <= rows_act_i;
                        tstart_q  <= 1'b1;
                        tlen_q    <= DEB_LEN;
                        state_q   <= ST_DEBOUNCE;
                    end
                end
                ST_DEBOUNCE: begin
                    if (tmr_done_i) begin
                        tstart_q <= 1'b1;
                        if (latched_q == '0) begin
                            tlen_q  <= DEB_LEN;
                            state_q <= ST_CLOSE;
                        end else begin
                            drive_q <= COL_FIRST;
                            found_q <= 1'b0;
                            tlen_q  <= SET_LEN;
                            state_q <= ST_SCAN;
                        end
                    end
                end
                ST_SCAN: begin
                    if (tmr_done_i) begin
                        if (rows_act_i == latched_q && rows_act_i != '0) begin
                            found_q    <= 1'b1;
                            cand_q.row <= rows_act_i;
                            cand_q.col <= drive_q;
                        end
                        if (last_col(drive_q)) begin
                            state_q <= ST_REPORT;
                        end else begin
                            drive_q  <= next_col(drive_q);
                            tstart_q <= 1'b1;
                            tlen_q   <= SET_LEN;
                        end
                    end
                end
                ST_REPORT: begin
                    valid_q <= found_q;
                    if (found_q) code_q <= cand_q;
                    tstart_q <= 1'b1;
                    tlen_q   <= DEB_LEN;
                    state_q  <= ST_CLOSE;
                end
                ST_CLOSE: begin
                    if (tmr_done_i) begin
                        drive_q  <= '0;
                        tstart_q <= 1'b1;
                        tlen_q   <= SET_LEN;
                        state_q  <= ST_REARM;
                    end
                end
                ST_REARM: begin
                    if (tmr_done_i) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign tmr_start_o = tstart_q;
    assign tmr_len_o   = tlen_q;
    assign col_o       = drive_q;
    assign code_o      = code_q;
    assign valid_o     = valid_q;
    assign busy_o      = (state_q != ST_IDLE);

    // hold-length tracking for the settle check
    logic [KP_COLS-1:0] col_prev_q;
    logic [7:0]         hold_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            col_prev_q <= '0;
            hold_q     <= '0;
        end else begin
            col_prev_q <= col_o;
            if (col_o != col_prev_q) hold_q <= 8'd1;
            else if (hold_q != 8'hFF) hold_q <= hold_q + 8'd1;
        end
    end

    p_idle_cols_r1: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (col_o == '0 && !valid_o));

    p_single_col_r4: assert property (@(posedge clk) disable iff (rst)
        (col_o != '0) |-> ($countones(col_o) == KP_COLS - 1));

    p_first_col_r4: assert property (@(posedge clk) disable iff (rst)
        ($past(col_o) == '0 && col_o != '0) |-> (col_o == COL_FIRST));

    p_col_order_r4: assert property (@(posedge clk) disable iff (rst)
        (col_o != $past(col_o) && $past(col_o) != '0 && col_o != '0)
            |-> (col_o == next_col($past(col_o))));

    p_settle_r4: assert property (@(posedge clk) disable iff (rst)
        (col_o != col_prev_q && col_prev_q != '0) |-> (hold_q >= 8'(SETTLE_CYC)));

    p_code_fmt_r5: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> (code_o.row != '0 && $countones(code_o.col) == KP_COLS - 1));

    p_valid_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);

    p_code_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !valid_o |-> $stable(code_o));

    p_release_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (busy_o && latched_q == '0) |-> (!valid_o && col_o == '0));
endmodule

// File: rtl/kp_scanner.sv
module kp_scanner
    import kp_pkg::*;
#(
    parameter int DEB_CYC    = 1000000,
    parameter int SETTLE_CYC = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [KP_ROWS-1:0]   row_n_i,
    output logic [KP_COLS-1:0]   col_o,
    output logic [KP_CODE_W-1:0] key_code_o,
    output logic                 key_valid_o,
    output logic                 busy_o
);
    localparam int MAX_CYC = (DEB_CYC > SETTLE_CYC) ? DEB_CYC : SETTLE_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    logic [KP_ROWS-1:0] rows_sync;
    logic [KP_ROWS-1:0] rows_act;
    logic               tmr_start;
    logic [CNT_W-1:0]   tmr_len;
    logic               tmr_done;
    kp_code_t           code;

    kp_row_sync #(.W(KP_ROWS)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (row_n_i),
        .q_o (rows_sync)
    );

    assign rows_act = ~rows_sync;

    kp_delay_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .start_i (tmr_start),
        .len_i   (tmr_len),
        .done_o  (tmr_done)
    );

    kp_scan_ctrl #(
        .DEB_CYC    (DEB_CYC),
        .SETTLE_CYC (SETTLE_CYC),
        .CNT_W      (CNT_W)
    ) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .rows_act_i  (rows_act),
        .tmr_done_i  (tmr_done),
        .tmr_start_o (tmr_start),
        .tmr_len_o   (tmr_len),
        .col_o       (col_o),
        .code_o      (code),
        .valid_o     (key_valid_o),
        .busy_o      (busy_o)
    );

    assign key_code_o = code;
endmodule

// File: tb/tb_kp_scanner.sv
module tb_kp_scanner;
    localparam int DEB = 40;
    localparam int SET = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] row_n;
    logic [3:0] col;
    logic [7:0] code;
    logic       valid;
    logic       busy;
    logic [15:0] pressed = '0;   // bit r*4+c: key at row r, column c

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    kp_scanner #(.DEB_CYC(DEB), .SETTLE_CYC(SET)) dut (
        .clk         (clk),
        .rst         (rst),
        .row_n_i     (row_n),
        .col_o       (col),
        .key_code_o  (code),
        .key_valid_o (valid),
        .busy_o      (busy)
    );

    // key matrix model: a pressed key shorts its row to a low column
    always_comb begin
        for (int r = 0; r < 4; r++) begin
            row_n[r] = 1'b1;
            for (int c = 0; c < 4; c++)
                if (pressed[r*4+c] && !col[c]) row_n[r] = 1'b0;
        end
    end

    function automatic logic [7:0] key_code(input int r, input int c);
        logic [3:0] rb = 4'b0001 << r;
        logic [3:0] cb = ~(4'b0001 << c);
        return {rb, cb};
    endfunction

    function automatic logic [3:0] exp_col(input int idx);
        return ~(4'b1000 >> idx);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // follow one busy period and check it against the expectations
    task automatic run_event(input int exp_n, input logic [7:0] exp_code, input string req,
                             input bit exp_scan, input int deb_min);
        int waitc = 0;
        int t = 0, nval = 0, t_scan = -1, t_val = 0, idx = 0, hold = 0;
        bit order_ok = 1, hold_ok = 1;
        logic [7:0] got = '0;
        logic [3:0] prev;
        while (!busy && waitc < 10) begin @(negedge clk); waitc++; end
        chk(busy, "R2 busy after row change", 32'(busy), 1);
        prev = col;
        while (busy && t < 20000) begin
            @(negedge clk);
            t++;
            if (valid) begin nval++; got = code; t_val = t; end
            if (col != prev) begin
                if (prev != 4'b0 && hold < SET) hold_ok = 0;
                if (col != 4'b0) begin
                    if (t_scan < 0) t_scan = t;
                    if (idx > 3 || col != exp_col(idx)) order_ok = 0;
                    idx++;
                end
                hold = 1;
            end else begin
                hold++;
            end
            prev = col;
        end
        chk(nval == exp_n, {req, " strobe count (R9 single cycle)"}, 32'(nval), 32'(exp_n));
        if (exp_n == 1) begin
            chk(got == exp_code, {req, " key code (R5)"}, 32'(got), 32'(exp_code));
            chk(t - t_val >= DEB, "R10 closing delay", 32'(t - t_val), DEB);
        end
        if (exp_scan) begin
            chk(t_scan >= deb_min, "R3 debounce before scan", 32'(t_scan), 32'(deb_min));
            chk(order_ok && idx == 4, "R4 column order", 32'(idx), 4);
            chk(hold_ok, "R4 settle hold", 32'(hold_ok), 1);
        end else begin
            chk(t_scan < 0, "R8 no scan on release", 32'(t_scan), 32'hFFFFFFFF);
        end
        chk(col == 4'b0 && !busy, "R1 idle after event", {27'b0, busy, col}, 0);
    endtask

    task automatic t_reset();
        chk(col == 4'b0, "R1 reset columns", 32'(col), 0);
        chk(!busy, "R1 reset busy", 32'(busy), 0);
        chk(!valid, "R1 reset valid", 32'(valid), 0);
    endtask

    task automatic t_single(input int r, input int c);
        @(negedge clk);
        pressed = 16'b1 << (r*4 + c);
        run_event(1, key_code(r, c), "R5 single key", 1, DEB);
        pressed = '0;
        run_event(0, 8'h00, "R8 release", 0, DEB);
    endtask

    task automatic t_fixed_codes();
        chk(key_code(0, 3) == 8'h17, "R5 code rule row0 col3", 32'(key_code(0, 3)), 32'h17);
        chk(key_code(3, 0) == 8'h8E, "R5 code rule row3 col0", 32'(key_code(3, 0)), 32'h8E);
    endtask

    task automatic t_same_row();
        // row 1 at columns 3 and 0: both match, column 0 is scanned last
        @(negedge clk);
        pressed = (16'b1 << 7) | (16'b1 << 4);
        run_event(1, 8'h2E, "R7 last match wins", 1, DEB);
        pressed = '0;
        run_event(0, 8'h00, "R8 release", 0, DEB);
    endtask

    task automatic t_same_col();
        // rows 0 and 1 on column 2: pattern 0011, nibble 1011
        @(negedge clk);
        pressed = (16'b1 << 2) | (16'b1 << 6);
        run_event(1, 8'h3B, "R5 two rows one column", 1, DEB);
        pressed = '0;
        run_event(0, 8'h00, "R8 release", 0, DEB);
    endtask

    task automatic t_mismatch();
        // row0/col3 and row1/col0: no column reproduces pattern 0011
        @(negedge clk);
        pressed = (16'b1 << 3) | (16'b1 << 4);
        run_event(0, 8'h00, "R6 no matching column", 1, DEB);
        pressed = '0;
        run_event(0, 8'h00, "R8 release", 0, DEB);
    endtask

    task automatic t_bounce();
        @(negedge clk);
        pressed = 16'b1 << 10;
        repeat (5) @(negedge clk);
        pressed = '0;
        repeat (3) @(negedge clk);
        pressed = 16'b1 << 10;
        run_event(1, key_code(2, 2), "R3 bounce ignored", 1, DEB - 12);
        repeat (20) @(negedge clk);
        chk(!busy && !valid, "R3 no extra event after bounce", 32'(busy), 0);
        pressed = '0;
        run_event(0, 8'h00, "R8 release", 0, DEB);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        t_reset();
        t_fixed_codes();
        t_single(0, 3);
        t_single(3, 0);
        t_single(1, 2);
        t_single(2, 1);
        t_same_row();
        t_same_col();
        t_mismatch();
        t_bounce();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule